// File: doc/BRIEF.md
# Multi-Comparator Event Timer

The block is a memory-mapped event timer. It has one 64-bit main counter that counts up by one on every clock while a global run bit is set, and three comparator channels that watch it. When the counter reaches a channel's comparator value, the channel latches a status bit. That bit stays set until software clears it, and the channel drives one interrupt line while its enable bit is set. Channel 0 can reload itself: in periodic mode it adds a programmed period to its comparator on each match, so matches follow at exact intervals without drift. Channels 1 and 2 fire once and then wait until software rearms them.

Software reaches the block through a single-cycle register bus with a 64-bit data path and combinational read data. Each channel has a fixed, read-only mask of the interrupt lines it may drive. A route selection outside that mask is rejected. Several channels may share one line, which is then the OR of their requests.

Each channel runs a three-state machine. IDLE means the channel is disabled. ARMED means it is waiting for a match. SPENT means a one-shot match has occurred. The transitions are:
- arm (IDLE to ARMED): the enable bit is seen set.
- expire (ARMED to SPENT): a match occurs in one-shot mode.
- reload (ARMED to ARMED): a match occurs in periodic mode.
- rearm (SPENT to ARMED): the comparator is written with a value ahead of the counter.
- disable (any state to IDLE): the enable bit is seen clear.

Top module: `evt_timer`

## Requirements
- R1: After reset, the counter is 0 and halted, all status bits are 0, every channel is disabled with route field 20, and all interrupt lines are low.
- R2: The capability word at address 0x00 reads the tick period in femtoseconds in bits [63:32] (default 100000000) and the channel count in bits [7:0]. The counter at 0x03 advances by exactly one per clock while bit 0 of the config word at 0x01 is 1, and holds while that bit is 0.
- R3: A write to the counter at 0x03 loads it only while the counter is halted. While the counter runs, such a write is ignored.
- R4: If an enabled channel n sees the running counter equal its comparator, it sets bit n of the status word at 0x02 one clock later, and its routed interrupt line goes high in the same cycle.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R6: A one-shot channel fires once per match. A comparator write that is not ahead of the counter leaves it spent. A comparator write ahead of the counter rearms it.
- R7: In periodic mode (channel config bit 1), channel 0 adds its period register (channel base +2) to its comparator on each match, so matches occur at C, C+P, C+2P and so on.
- R8: Only channel 0 can be periodic. Channel config bit 2 reads 1 only for channel 0. On channels 1 and 2, bit 1 ignores writes and reads 0.
- R9: Channel config bits [63:32] read the channel's fixed route mask. Bits [12:8] hold the route. A route write whose mask bit is 0 is ignored, and the field keeps its old value.
- R10: Interrupt line k is high whenever at least one enabled channel with its status set is routed to k. Lines are shared.
- R11: A disabled channel (config bit 0 clear) never sets its status bit, even on a counter match.

Channel n occupies addresses 0x10+4n (config), 0x11+4n (comparator) and 0x12+4n (period).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr (combinational) |
| irq_lines | output | 24 | Level interrupt lines, one per line number |

## Verification
The bench times a one-shot match to the exact cycle. A design that compared against a stale counter, or registered the status once too often, would raise the line a cycle early or late. The periodic test reads the comparator back after two matches. A design that reloaded from the counter instead of the comparator would drift, and one that rearmed the one-shot channels would fire them again. Rejected route writes, writes of 0 to the status word, and counter writes while running are each read back at the ports, where a design that accepted them would show the changed value. Two channels sharing one line are cleared one at a time, so an overwrite in place of an OR would drop the line early.

// File: rtl/evt_pkg.sv
package evt_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_SPENT = 2'd2
    } ch_state_e;

    localparam int          ADDR_W    = 8;
    localparam logic [7:0]  A_CAP     = 8'h00;
    localparam logic [7:0]  A_CFG     = 8'h01;
    localparam logic [7:0]  A_STAT    = 8'h02;
    localparam logic [7:0]  A_COUNT   = 8'h03;
    localparam logic [7:0]  A_CH_BASE = 8'h10;

    localparam int EN_BIT    = 0;
    localparam int PER_BIT   = 1;
    localparam int ROUTE_LSB = 8;
    localparam int ROUTE_W   = 5;
endpackage

// File: rtl/evt_counter.sv
module evt_counter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cnt_we,
    input  logic [63:0] wdata,
    output logic        run,
    output logic [63:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else begin
            if (cfg_we)
                run <= wdata[0];
            if (run)
                cnt <= cnt + 64'd1;
            else if (cnt_we)
                cnt <= wdata;
        end
    end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter bit          PERIODIC_OK = 1'b0,
    parameter logic [31:0] ROUTE_CAP   = 32'h00F0_0000,
    parameter int          ROUTE_RST   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [63:0]        cnt,
    input  logic               run,
    input  logic               cfg_we,
    input  logic               cmp_we,
    input  logic               per_we,
    input  logic [63:0]        wdata,
    input  logic               clr,
    output logic               status,
    output logic               en,
    output logic [ROUTE_W-1:0] route,
    output logic [63:0]        cfg_rd,
    output logic [63:0]        cmp_rd,
    output logic [63:0]        per_rd
);
    ch_state_e   state_q, state_d;
    logic [63:0] cmp_q;
    logic [63:0] per_q;
    logic        per_mode;
    logic        hit, fire, ahead;
    logic [ROUTE_W-1:0] route_req;

    assign hit       = run && (cnt == cmp_q);
    assign fire      = (state_q == CH_ARMED) && hit;
    assign ahead     = cmp_we && (wdata > cnt);
    assign route_req = wdata[ROUTE_LSB +: ROUTE_W];

    generate
        if (PERIODIC_OK) begin : g_periodic
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    per_mode <= 1'b0;
                    per_q    <= '0;
                end else begin
                    if (cfg_we)
                        per_mode <= wdata[PER_BIT];
                    if (per_we)
                        per_q <= wdata;
                end
            end
        end else begin : g_oneshot
            assign per_mode = 1'b0;
            assign per_q    = '0;
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  if (en) state_d = CH_ARMED;
            CH_ARMED: begin
                if (!en)
                    state_d = CH_IDLE;
                else if (fire && !per_mode)
                    state_d = CH_SPENT;
            end
            CH_SPENT: begin
                if (!en)
                    state_d = CH_IDLE;
                else if (ahead)
                    state_d = CH_ARMED;
            end
            default:  state_d = CH_IDLE;
        endcase
    end

    // Outputs and channel registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en     <= 1'b0;
            route  <= ROUTE_W'(ROUTE_RST);
            cmp_q  <= '1;
            status <= 1'b0;
        end else begin
            if (cfg_we) begin
                en <= wdata[EN_BIT];
                if (ROUTE_CAP[route_req])
                    route <= route_req;
            end
            if (cmp_we)
                cmp_q <= wdata;
            else if (fire && per_mode)
                cmp_q <= cmp_q + per_q;
            status <= (status & ~clr) | fire;
        end
    end

    assign cfg_rd = {ROUTE_CAP, 19'd0, route, 5'd0, PERIODIC_OK, per_mode, en};
    assign cmp_rd = cmp_q;
    assign per_rd = per_q;
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route
    import evt_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int NUM_LINES = 24
) (
    input  logic [NUM_CH-1:0]         status,
    input  logic [NUM_CH-1:0]         en,
    input  logic [NUM_CH*ROUTE_W-1:0] route,
    output logic [NUM_LINES-1:0]      irq
);
    generate
        for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
            logic [NUM_CH-1:0] req;
            for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
                assign req[c] = status[c] && en[c] &&
                                (route[c*ROUTE_W +: ROUTE_W] == ROUTE_W'(k));
            end
            assign irq[k] = |req;
        end
    endgenerate
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int              NUM_CH     = 3,
    parameter int              NUM_LINES  = 24,
    parameter logic [31:0]     TICK_FS    = 32'd100_000_000,
    parameter logic [NUM_CH*32-1:0] ROUTE_CAPS = 96'h00F0_0800_00F0_0000_00F0_0004,
    parameter int              ROUTE_RST  = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [63:0]          bus_wdata,
    output logic [63:0]          bus_rdata,
    output logic [NUM_LINES-1:0] irq_lines
);
    localparam logic [5:0] NUM_CH6 = 6'(NUM_CH);

    logic                      run;
    logic [63:0]               cnt;
    logic [NUM_CH-1:0]         status;
    logic [NUM_CH-1:0]         en;
    logic [NUM_CH*ROUTE_W-1:0] route;
    logic [63:0]               cfg_rd [NUM_CH];
    logic [63:0]               cmp_rd [NUM_CH];
    logic [63:0]               per_rd [NUM_CH];

    logic [7:0] ch_off;
    logic [5:0] ch_idx;
    logic [1:0] ch_sub;
    logic       in_ch;

    assign ch_off = bus_addr - A_CH_BASE;
    assign ch_idx = ch_off[7:2];
    assign ch_sub = ch_off[1:0];
    assign in_ch  = (bus_addr >= A_CH_BASE) && (ch_idx < NUM_CH6);

    evt_counter u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_we (bus_wr && bus_addr == A_CFG),
        .cnt_we (bus_wr && bus_addr == A_COUNT),
        .wdata  (bus_wdata),
        .run    (run),
        .cnt    (cnt)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            logic sel;
            assign sel = in_ch && (ch_idx == 6'(i));
            evt_channel #(
                .PERIODIC_OK (i == 0),
                .ROUTE_CAP   (ROUTE_CAPS[i*32 +: 32]),
                .ROUTE_RST   (ROUTE_RST)
            ) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .cnt    (cnt),
                .run    (run),
                .cfg_we (bus_wr && sel && ch_sub == 2'd0),
                .cmp_we (bus_wr && sel && ch_sub == 2'd1),
                .per_we (bus_wr && sel && ch_sub == 2'd2),
                .wdata  (bus_wdata),
                .clr    (bus_wr && bus_addr == A_STAT && bus_wdata[i]),
                .status (status[i]),
                .en     (en[i]),
                .route  (route[i*ROUTE_W +: ROUTE_W]),
                .cfg_rd (cfg_rd[i]),
                .cmp_rd (cmp_rd[i]),
                .per_rd (per_rd[i])
            );
        end
    endgenerate

    evt_irq_route #(
        .NUM_CH    (NUM_CH),
        .NUM_LINES (NUM_LINES)
    ) u_route (
        .status (status),
        .en     (en),
        .route  (route),
        .irq    (irq_lines)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CAP:   bus_rdata = {TICK_FS, 24'd0, 8'(NUM_CH)};
            A_CFG:   bus_rdata = {63'd0, run};
            A_STAT:  bus_rdata = {{(64-NUM_CH){1'b0}}, status};
            A_COUNT: bus_rdata = cnt;
            default: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (in_ch && ch_idx == 6'(i)) begin
                        if (ch_sub == 2'd0)      bus_rdata = cfg_rd[i];
                        else if (ch_sub == 2'd1) bus_rdata = cmp_rd[i];
                        else if (ch_sub == 2'd2) bus_rdata = per_rd[i];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int NUM_LINES = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [63:0]          bus_wdata,
    input logic                 run,
    input logic [63:0]          cnt,
    input logic [NUM_CH-1:0]    status,
    input logic [NUM_LINES-1:0] irq_lines
);
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt == $past(cnt) + 64'd1));

    a_r2_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(bus_wr && bus_addr == A_COUNT)) |=> $stable(cnt));

    a_r3_no_load_running: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bus_wr && bus_addr == A_COUNT) |=> (cnt == $past(cnt) + 64'd1));

    a_r10_line_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_lines) |-> (|status));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
            a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (status[i] && !(bus_wr && bus_addr == A_STAT && bus_wdata[i])) |=> status[i]);

            a_r4_set_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(status[i]) |-> $past(run));
        end
    endgenerate
endmodule

bind evt_timer evt_timer_chk #(
    .NUM_CH    (NUM_CH),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run       (run),
    .cnt       (cnt),
    .status    (status),
    .irq_lines (irq_lines)
);

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [23:0] irq_lines;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evt_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_lines (irq_lines)
    );

    function automatic logic [7:0] ch_cfg(int n); return 8'(8'h10 + 4*n); endfunction
    function automatic logic [7:0] ch_cmp(int n); return 8'(8'h11 + 4*n); endfunction
    function automatic logic [7:0] ch_per(int n); return 8'(8'h12 + 4*n); endfunction
    function automatic logic [63:0] cfg_word(int route, bit per, bit en);
        return (64'(route) << 8) | (64'(per) << 1) | 64'(en);
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [63:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [63:0] d);
        @(posedge clk); #1;
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic quiesce();
        wr(8'h01, 64'd0);
        for (int c = 0; c < 3; c++) wr(ch_cfg(c), 64'd0);
        wr(8'h02, 64'h7);
        wr(8'h03, 64'd0);
    endtask

    task automatic t_reset();
        logic [63:0] v;
        check("R1 irq", 64'(irq_lines), 64'd0);
        rd(8'h00, v); check("R2 capability", v, {32'd100_000_000, 32'd3});
        rd(8'h01, v); check("R1 halted", v, 64'd0);
        rd(8'h02, v); check("R1 status", v, 64'd0);
        rd(8'h03, v); check("R1 count", v, 64'd0);
        rd(ch_cfg(0), v); check("R1 ch0 cfg", v, {32'h00F0_0004, 32'd0} | cfg_word(20, 0, 0) | 64'h4);
        rd(ch_cfg(2), v); check("R1 ch2 cfg", v, {32'h00F0_0800, 32'd0} | cfg_word(20, 0, 0));
    endtask

    task automatic t_count();
        logic [63:0] a, b;
        quiesce();
        wr(8'h03, 64'd100);
        rd(8'h03, a); check("R3 load halted", a, 64'd100);
        wr(8'h01, 64'd1);
        rd(8'h03, a);
        tick(9);
        rd(8'h03, b); check("R2 step per clock", b - a, 64'd10);
        rd(8'h03, a);
        wr(8'h03, 64'd5);
        rd(8'h03, b); check("R3 load ignored running", b, a + 64'd3);
        wr(8'h01, 64'd0);
        rd(8'h03, a);
        tick(8);
        rd(8'h03, b); check("R2 hold halted", b, a);
    endtask

    task automatic t_oneshot();
        logic [63:0] v, c;
        quiesce();
        wr(ch_cmp(1), 64'd20);
        wr(ch_cfg(1), cfg_word(21, 0, 1));
        wr(8'h01, 64'd1);
        tick(20); check("R4 line low before match", 64'(irq_lines[21]), 64'd0);
        tick(1);  check("R4 line high after match", 64'(irq_lines[21]), 64'd1);
        rd(8'h02, v); check("R4 status bit1", v, 64'h2);
        wr(8'h02, 64'h0);
        rd(8'h02, v); check("R5 write 0 keeps", v, 64'h2);
        wr(8'h02, 64'h2);
        rd(8'h02, v); check("R5 write 1 clears", v, 64'h0);
        check("R5 line drops", 64'(irq_lines[21]), 64'd0);
        wr(ch_cmp(1), 64'd5);
        tick(40);
        rd(8'h02, v); check("R6 behind write stays spent", v, 64'h0);
        rd(8'h03, c);
        wr(ch_cmp(1), c + 64'd20);
        tick(40);
        rd(8'h02, v); check("R6 ahead write rearms", v, 64'h2);
    endtask

    task automatic t_periodic();
        logic [63:0] v;
        quiesce();
        wr(ch_cmp(0), 64'd10);
        wr(ch_per(0), 64'd7);
        wr(ch_cfg(0), cfg_word(22, 1, 1));
        rd(ch_cfg(0), v); check("R8 ch0 periodic bits", v[2:0], 64'h7);
        wr(8'h01, 64'd1);
        tick(10); check("R7 no early match", 64'(irq_lines[22]), 64'd0);
        tick(1);  check("R7 first match", 64'(irq_lines[22]), 64'd1);
        rd(ch_cmp(0), v); check("R7 reload C+P", v, 64'd17);
        wr(8'h02, 64'h1);
        check("R7 cleared", 64'(irq_lines[22]), 64'd0);
        tick(3); check("R7 no match before C+P", 64'(irq_lines[22]), 64'd0);
        tick(1); check("R7 second match", 64'(irq_lines[22]), 64'd1);
        rd(ch_cmp(0), v); check("R7 reload C+2P", v, 64'd24);
    endtask

    task automatic t_caps();
        logic [63:0] v;
        quiesce();
        wr(ch_cfg(2), cfg_word(20, 1, 0));
        rd(ch_cfg(2), v); check("R8 ch2 periodic ignored", v[2:0], 64'h0);
        rd(ch_cfg(1), v); check("R8 ch1 not capable", v[2:0], 64'h0);
        check("R9 ch1 mask", v[63:32], 64'h00F0_0000);
        wr(ch_cfg(1), cfg_word(2, 0, 0));
        rd(ch_cfg(1), v); check("R9 bad route ignored", v[12:8], 64'd21);
        wr(ch_cfg(0), cfg_word(2, 0, 0));
        rd(ch_cfg(0), v); check("R9 allowed route taken", v[12:8], 64'd2);
    endtask

    task automatic t_shared();
        logic [63:0] v;
        quiesce();
        wr(ch_cmp(1), 64'd5);
        wr(ch_cmp(2), 64'd8);
        wr(ch_cfg(1), cfg_word(23, 0, 1));
        wr(ch_cfg(2), cfg_word(23, 0, 1));
        wr(8'h01, 64'd1);
        tick(20);
        rd(8'h02, v); check("R10 both status", v, 64'h6);
        check("R10 shared line", 64'(irq_lines), 64'h80_0000);
        wr(8'h02, 64'h2);
        check("R10 line held by other", 64'(irq_lines[23]), 64'd1);
        wr(8'h02, 64'h4);
        check("R10 line released", 64'(irq_lines[23]), 64'd0);
    endtask

    task automatic t_disabled();
        logic [63:0] v;
        quiesce();
        wr(ch_cmp(2), 64'd5);
        wr(ch_cfg(2), cfg_word(23, 0, 0));
        wr(8'h01, 64'd1);
        tick(20);
        rd(8'h02, v); check("R11 disabled no status", v, 64'h0);
        check("R11 disabled no line", 64'(irq_lines), 64'd0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_count();
        t_oneshot();
        t_periodic();
        t_caps();
        t_shared();
        t_disabled();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected completion");
            summary();
        end
    end
endmodule